// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit does decimal arithmetic on bytes that each hold two packed BCD digits. It supports three operations. Add computes destination plus source plus the extend bit. Subtract computes destination minus source minus the extend bit. Negate computes zero minus source minus the extend bit. A request is one cycle with the strobe high, an operation code, both operands, the incoming extend bit and the incoming zero flag. On the next clock edge the unit registers a BCD byte and updated carry, extend and zero flags, and pulses a done signal.

No per-digit compare-and-branch is used. The sum is biased by six in every digit. The carries that cross each digit boundary are recovered by XOR. Six is then taken back from each digit that did not carry. Subtraction uses the same adder: it adds a nines-style complement of the source, and the borrow becomes a carry-in. The zero flag can only be cleared, never set. This lets a chain of byte operations over a long decimal number report whether the whole number is zero. If an operand digit is not valid BCD, the result is unspecified.

Top module: `bcd_byte_alu`

## Requirements
- R1: With op_i = 2'b00 (add), result_o holds the low two BCD digits of dst + src + x_i. c_o is 1 when that decimal sum is 100 or more.
- R2: With op_i = 2'b01 (subtract), result_o holds the two BCD digits of dst − src − x_i modulo 100. c_o is 1 when the difference is negative (borrow).
- R3: With op_i = 2'b10 (negate), dst_i is ignored. The result is 0 − src − x_i modulo 100, and c_o is 1 unless src and x_i are both zero.
- R4: x_o always equals c_o after every update.
- R5: After an add, subtract or negate, z_o is 0 if the result byte is nonzero. Otherwise z_o equals the z_i presented with the request, so z_o is never set from 0.
- R6: op_i = 2'b11 is reserved. It pulses done_o but leaves result_o, c_o, x_o and z_o unchanged.
- R7: done_o is high exactly in the cycle after a cycle with valid_i high. The result and flags for that request are visible in the same cycle.
- R8: When valid_i is low, result_o and all flags hold their values whatever the other inputs do.
- R9: A synchronous active-high reset clears result_o, c_o, x_o and done_o, and sets z_o to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 negate, 11 reserved |
| dst_i | input | 8 | Destination operand, two packed BCD digits |
| src_i | input | 8 | Source operand, two packed BCD digits |
| x_i | input | 1 | Incoming extend bit (carry or borrow in) |
| z_i | input | 1 | Incoming zero flag |
| result_o | output | 8 | Registered BCD result |
| c_o | output | 1 | Decimal carry or borrow out |
| x_o | output | 1 | Extend out, copy of the carry |
| z_o | output | 1 | Sticky zero flag |
| done_o | output | 1 | Pulse one cycle after valid_i |

## Verification
Every cycle, the assertions check the following:
- done_o follows valid_i by one cycle.
- The carry and extend outputs stay equal.
- Outputs stay stable when there is no request or the op is reserved.
- Z is never set against z_i and is always cleared by a nonzero result.
- The result is valid BCD whenever both operands were valid BCD.
- The reset values appear after reset.

Only the bench's sweep can show the decimal values. It covers every operand pair with both extend values for all three operations, compared against integer arithmetic. The bench also shows that negate ignores the destination operand.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_NEG = 2'b10,
    OP_RSV = 2'b11
  } bcd_op_e;

  // Constant holding the value 6 in each of the given number of digits.
  function automatic logic [63:0] six_per_digit(input int digits);
    logic [63:0] v;
    v = '0;
    for (int i = 0; i < digits; i++) begin
      v = v | (64'h6 << (4 * i));
    end
    return v;
  endfunction

endpackage

// File: rtl/bcd_operand_prep.sv
module bcd_operand_prep
  import bcd_alu_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [1:0]        op,
  input  logic [4*DIGITS-1:0] dst,
  input  logic [4*DIGITS-1:0] src,
  input  logic              x_in,
  output logic [4*DIGITS:0] addend_a,
  output logic [4*DIGITS:0] addend_b,
  output logic              carry_in,
  output logic              active
);
  localparam int W = 4 * DIGITS;
  localparam logic [63:0] BIAS64 = six_per_digit(DIGITS);
  localparam logic [W:0] BIAS = BIAS64[W:0];
  localparam logic [W:0] ALL1 = '1;

  logic [W:0] src_ext;
  logic [W:0] dst_ext;

  assign src_ext = {1'b0, src};
  assign dst_ext = {1'b0, dst};

  always_comb begin
    addend_a = '0;
    addend_b = '0;
    carry_in = 1'b0;
    active   = 1'b1;
    case (bcd_op_e'(op))
      OP_ADD: begin
        addend_a = src_ext + BIAS;
        addend_b = dst_ext;
        carry_in = x_in;
      end
      OP_SUB: begin
        // The complement already carries the six-per-digit bias.
        addend_a = ALL1 - src_ext;
        addend_b = dst_ext;
        carry_in = ~x_in;
      end
      OP_NEG: begin
        addend_a = ALL1 - src_ext;
        addend_b = '0;
        carry_in = ~x_in;
      end
      default: begin
        active = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bcd_bias_adder.sv
module bcd_bias_adder
  import bcd_alu_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS:0] addend_a,
  input  logic [4*DIGITS:0] addend_b,
  input  logic              carry_in,
  output logic [4*DIGITS:0] sum
);
  localparam int W = 4 * DIGITS;
  localparam logic [W:0] SIX = (W + 1)'(6);

  logic [W:0] raw;
  logic [W:0] no_carry_sum;
  logic [W:0] boundary;
  logic [W:0] fix [DIGITS];
  logic [W:0] corr;

  assign raw          = addend_a + addend_b + {{W{1'b0}}, carry_in};
  assign no_carry_sum = addend_a ^ addend_b;
  assign boundary     = raw ^ no_carry_sum;

  // One correction term per digit: six back out where the digit did not carry.
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign fix[g] = boundary[4*(g+1)] ? '0 : (SIX << (4 * g));
  end

  always_comb begin
    corr = '0;
    for (int i = 0; i < DIGITS; i++) begin
      corr = corr + fix[i];
    end
  end

  assign sum = raw - corr;
endmodule

// File: rtl/bcd_flag_unit.sv
module bcd_flag_unit #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS:0]   sum,
  input  logic                z_in,
  output logic [4*DIGITS-1:0] res_nxt,
  output logic                c_nxt,
  output logic                z_nxt
);
  localparam int W = 4 * DIGITS;

  assign res_nxt = sum[W-1:0];
  assign c_nxt   = sum[W];
  assign z_nxt   = z_in & (sum[W-1:0] == '0);
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu #(
  parameter int DIGITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_i,
  input  logic [1:0]           op_i,
  input  logic [4*DIGITS-1:0]  dst_i,
  input  logic [4*DIGITS-1:0]  src_i,
  input  logic                 x_i,
  input  logic                 z_i,
  output logic [4*DIGITS-1:0]  result_o,
  output logic                 c_o,
  output logic                 x_o,
  output logic                 z_o,
  output logic                 done_o
);
  localparam int W = 4 * DIGITS;

  logic [W:0]   add_a;
  logic [W:0]   add_b;
  logic         cin;
  logic         op_active;
  logic [W:0]   sum;
  logic [W-1:0] res_nxt;
  logic         c_nxt;
  logic         z_nxt;

  bcd_operand_prep #(.DIGITS(DIGITS)) u_prep (
    .op       (op_i),
    .dst      (dst_i),
    .src      (src_i),
    .x_in     (x_i),
    .addend_a (add_a),
    .addend_b (add_b),
    .carry_in (cin),
    .active   (op_active)
  );

  bcd_bias_adder #(.DIGITS(DIGITS)) u_adder (
    .addend_a (add_a),
    .addend_b (add_b),
    .carry_in (cin),
    .sum      (sum)
  );

  bcd_flag_unit #(.DIGITS(DIGITS)) u_flags (
    .sum     (sum),
    .z_in    (z_i),
    .res_nxt (res_nxt),
    .c_nxt   (c_nxt),
    .z_nxt   (z_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      c_o      <= 1'b0;
      x_o      <= 1'b0;
      z_o      <= 1'b1;
      done_o   <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i && op_active) begin
        result_o <= res_nxt;
        c_o      <= c_nxt;
        x_o      <= c_nxt;
        z_o      <= z_nxt;
      end
    end
  end
endmodule

// File: rtl/bcd_byte_alu_chk.sv
module bcd_byte_alu_chk #(
  parameter int DIGITS = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                valid_i,
  input logic [1:0]          op_i,
  input logic [4*DIGITS-1:0] dst_i,
  input logic [4*DIGITS-1:0] src_i,
  input logic                z_i,
  input logic [4*DIGITS-1:0] result_o,
  input logic                c_o,
  input logic                x_o,
  input logic                z_o,
  input logic                done_o
);
  localparam int W = 4 * DIGITS;

  function automatic logic is_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  logic past_ok  = 1'b0;
  logic prev_rst = 1'b0;

  always_ff @(posedge clk) begin
    past_ok  <= !rst;
    prev_rst <= rst;
  end

  a_r9_reset_state: assert property (@(posedge clk)
    prev_rst |-> (result_o == '0) && !c_o && !x_o && z_o && !done_o);

  a_r7_done_latency: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> done_o == $past(valid_i));

  a_r4_carry_eq_extend: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> c_o == x_o);

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(valid_i) |-> $stable(result_o) && $stable(c_o) && $stable(z_o));

  a_r6_reserved_no_change: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(valid_i) && ($past(op_i) == 2'b11)
      |-> $stable(result_o) && $stable(c_o) && $stable(x_o) && $stable(z_o));

  a_r5_z_cleared: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(valid_i) && ($past(op_i) != 2'b11) && (result_o != '0) |-> !z_o);

  a_r5_z_never_set: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(valid_i) && ($past(op_i) != 2'b11) |-> !z_o || $past(z_i));

  a_r1_bcd_result: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(valid_i) && ($past(op_i) != 2'b11)
      && $past(is_bcd(src_i)) && $past(is_bcd(dst_i)) |-> is_bcd(result_o));
endmodule

bind bcd_byte_alu bcd_byte_alu_chk #(.DIGITS(DIGITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .dst_i    (dst_i),
  .src_i    (src_i),
  .z_i      (z_i),
  .result_o (result_o),
  .c_o      (c_o),
  .x_o      (x_o),
  .z_o      (z_o),
  .done_o   (done_o)
);

// File: tb/bcd_byte_alu_bench.sv
`timescale 1ns/1ps
module bcd_byte_alu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [7:0] dst_i = 8'h00;
  logic [7:0] src_i = 8'h00;
  logic       x_i = 1'b0;
  logic       z_i = 1'b0;
  logic [7:0] result_o;
  logic       c_o, x_o, z_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bcd_byte_alu u_bcd_byte_alu (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .x_i(x_i), .z_i(z_i),
    .result_o(result_o), .c_o(c_o), .x_o(x_o), .z_o(z_o), .done_o(done_o)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] pack_out();
    return {result_o, c_o, x_o, z_o, done_o};
  endfunction

  task automatic issue(input logic [1:0] op, input int d, input int s, input logic x, input logic z);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; dst_i = to_bcd(d); src_i = to_bcd(s); x_i = x; z_i = z;
    @(posedge clk); #1;
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [11:0] snap;
    repeat (3) @(posedge clk); #1;
    check("R9 reset state", pack_out(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b0});
    @(negedge clk); rst = 1'b0;

    // Exhaustive sweep of R1 add, R2 subtract and R3 negate, with R4, R5 and R7.
    for (int op = 0; op < 3; op++) begin
      for (int d = 0; d < 100; d++) begin
        for (int s = 0; s < 100; s++) begin
          for (int x = 0; x < 2; x++) begin
            int v, r;
            logic c, zi;
            zi = logic'((d + s + op) % 2) | (x == 0 && s == d);
            if (op == 0) v = d + s + x;
            else if (op == 1) v = d - s - x;
            else v = 0 - s - x;
            if (op == 0) begin c = (v >= 100); r = v % 100; end
            else if (v < 0) begin c = 1'b1; r = v + 100; end
            else begin c = 1'b0; r = v; end
            issue(2'(op), d, s, logic'(x), zi);
            check(op == 0 ? "R1 add" : (op == 1 ? "R2 sub" : "R3 neg"),
                  pack_out(), {to_bcd(r), c, c, zi & (r == 0), 1'b1});
          end
        end
      end
    end

    // R5: a zero result leaves an incoming clear Z clear.
    issue(2'b00, 0, 0, 1'b0, 1'b0);
    check("R5 zero result keeps z clear", pack_out(), {8'h00, 1'b0, 1'b0, 1'b0, 1'b1});

    // R3: the destination operand has no effect on negate.
    issue(2'b10, 73, 25, 1'b0, 1'b1);
    check("R3 negate ignores dst", pack_out(), {8'h75, 1'b1, 1'b1, 1'b0, 1'b1});

    // R8: idle cycles with changing inputs hold everything.
    snap = pack_out();
    @(negedge clk); op_i = 2'b00; dst_i = 8'h45; src_i = 8'h12; x_i = 1'b1; z_i = 1'b1;
    @(posedge clk); #1;
    check("R8 hold, done low", pack_out(), {snap[11:1], 1'b0});
    @(negedge clk); op_i = 2'b01; dst_i = 8'h00;
    repeat (2) @(posedge clk); #1;
    check("R8 hold over idle", pack_out(), {snap[11:1], 1'b0});

    // R6: reserved code pulses done only.
    issue(2'b11, 99, 99, 1'b1, 1'b0);
    check("R6 reserved no change", pack_out(), {snap[11:1], 1'b1});
    @(posedge clk); #1;
    check("R7 done single pulse", {11'h0, done_o}, 12'h000);

    // R9: reset in mid-run after a nonzero result.
    issue(2'b00, 12, 34, 1'b0, 1'b0);
    check("R1 before reset", pack_out(), {8'h46, 1'b0, 1'b0, 1'b0, 1'b1});
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    check("R9 mid-run reset", pack_out(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b0});
    @(negedge clk); rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule